// File: doc/BRIEF.md
# Programmable SCL Clock Generator

This block times the serial clock of a two-wire bus master from a fast system clock. A sequencer above it asks for one bus event at a time: a start (or repeated start) condition, one data bit, or a stop condition. The block releases SCL or pulls it low for the programmed number of system clocks. It also tells the sequencer when SDA may be changed and when SDA should be sampled. SCL is modelled as an open-drain line. The block drives `scl_low` and reads the wire back on `scl_in`. A slave that holds the wire low stretches the high phase, and the block flags this.

There are two sets of timing: a standard set and a fast set. Each set has a high count and a low count, and a speed bit selects which set is used. A low phase lasts the low count plus one system clock, counted from the first cycle SCL is pulled low. A high phase lasts the high count plus eight clocks in which SCL is seen high. The start-condition hold lasts the high count plus three clocks. An SDA hold count places the SDA launch strobe inside each low phase. The configuration can be written only while the block is disabled. Counts below the legal minimum are raised to that minimum when they are written.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `scl_low` is 0 and `sda_launch`, `sda_sample`, `sda_edge` and `stretch_det` are 0. `cmd_ready` equals `enable`.
- R2: Reset values come from `CLK_KHZ`, rounded to the nearest clock. The standard high count is round(4000 ns) − 8 and the standard low count is round(4700 ns) − 1. The fast high count is round(600 ns) − 8 and the fast low count is round(1300 ns) − 1. The SDA hold is 1 and the speed bit selects the standard set.
- R3: A low phase holds `scl_low` at 1 for exactly LCNT+1 cycles. After it, `scl_low` stays 1 and `cmd_ready` returns to 1.
- R4: A bit command (`cmd_op` = 2'b10) releases SCL for HCNT+8 cycles when no slave stretches the clock, and then runs one low phase. `sda_sample` pulses once, in the first released cycle in which `scl_in` is 1.
- R5: While SCL is released but `scl_in` is 0, `stretch_det` is 1 and the high-phase count does not advance. The released time grows by exactly the number of stretched cycles.
- R6: A start command (`cmd_op` = 2'b01) is accepted when idle or between bits. It first releases SCL for HCNT+8 cycles (setup) and pulses `sda_edge` in the last of them. It then keeps SCL released for HCNT+3 more cycles (hold) before a low phase begins.
- R7: A stop command (`cmd_op` = 2'b11) releases SCL for HCNT+8 cycles and pulses `sda_edge` in the last of them. The block then goes idle with SCL released and `cmd_ready` at 1.
- R8: `sda_launch` pulses exactly once per low phase, in cycle min(HOLD, LCNT), where the first low cycle is cycle 0.
- R9: Configuration address 5, bit 0, is the speed bit. When it is 1 the fast counts are used (address 2 for high, 3 for low). When it is 0 the standard counts are used (address 0 for high, 1 for low). Address 4 holds the SDA hold count.
- R10: A configuration write made while `enable` is 1 has no effect on any later phase length.
- R11: A high count written below 6 is stored as 6, and a low count written below 8 is stored as 8.
- R12: When `enable` is 0, the block goes idle on the next clock with SCL released. Bit and stop commands are ignored while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; configuration can be written only while it is 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address (0 std high, 1 std low, 2 fast high, 3 fast low, 4 SDA hold, 5 speed) |
| cfg_wdata | input | CNT_W | Configuration write data |
| cmd_valid | input | 1 | Command request, taken when `cmd_ready` is 1 |
| cmd_op | input | 2 | 01 start, 10 bit, 11 stop, 00 none |
| cmd_ready | output | 1 | Block is idle or parked between bits and takes a command |
| scl_in | input | 1 | Observed level of the SCL wire |
| scl_low | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_launch | output | 1 | SDA may change now (SDA hold point in the low phase) |
| sda_sample | output | 1 | SDA should be sampled now (first observed-high cycle of a bit) |
| sda_edge | output | 1 | Move SDA now to form the start or stop condition |
| stretch_det | output | 1 | SCL is released but seen low |

## Verification
The assertions assume that `scl_in` is already synchronous to `clk` and that it can be low only while SCL is pulled low or a slave stretches the clock. They also assume that commands arrive only while `cmd_ready` is 1, apart from the idle bit or stop command that must be ignored. The stimulus derives `scl_in` as the wired-AND of `scl_low` and a stretch signal. The stretch signal changes only at falling clock edges and only while SCL is released. Configuration is written only with `enable` low, except for the deliberate writes that check the lock.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    localparam int CFG_ADDR_W          = 3;
    localparam int HIGH_OVERHEAD       = 8;
    localparam int LOW_OVERHEAD        = 1;
    localparam int START_HOLD_OVERHEAD = 3;
    localparam int HCNT_MIN            = 6;
    localparam int LCNT_MIN            = 8;

    localparam int STD_HIGH_NS  = 4000;
    localparam int STD_LOW_NS   = 4700;
    localparam int FAST_HIGH_NS = 600;
    localparam int FAST_LOW_NS  = 1300;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START_SU, ST_START_HD, ST_HIGH, ST_LOW, ST_PARK, ST_STOP_SU
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_START = 2'b01,
        OP_BIT   = 2'b10,
        OP_STOP  = 2'b11
    } op_e;

    typedef enum logic [CFG_ADDR_W-1:0] {
        CFG_STD_HIGH  = 3'd0,
        CFG_STD_LOW   = 3'd1,
        CFG_FAST_HIGH = 3'd2,
        CFG_FAST_LOW  = 3'd3,
        CFG_HOLD      = 3'd4,
        CFG_SPEED     = 3'd5
    } cfg_addr_e;

    // nanoseconds to system clocks, rounded to nearest
    function automatic int ns_to_clk(int khz, int ns);
        longint prod;
        prod = longint'(khz) * longint'(ns) + 64'sd500000;
        return int'(prod / 64'sd1000000);
    endfunction

    function automatic int floor_at(int v, int lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
    import scl_gen_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CLK_KHZ = 100000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]      cfg_wdata,
    output logic [CNT_W-1:0]      hcnt_o,
    output logic [CNT_W-1:0]      lcnt_o,
    output logic [CNT_W-1:0]      hold_o
);
    localparam logic [CNT_W-1:0] RST_STD_H  =
        CNT_W'(floor_at(ns_to_clk(CLK_KHZ, STD_HIGH_NS) - HIGH_OVERHEAD, HCNT_MIN));
    localparam logic [CNT_W-1:0] RST_STD_L  =
        CNT_W'(floor_at(ns_to_clk(CLK_KHZ, STD_LOW_NS) - LOW_OVERHEAD, LCNT_MIN));
    localparam logic [CNT_W-1:0] RST_FAST_H =
        CNT_W'(floor_at(ns_to_clk(CLK_KHZ, FAST_HIGH_NS) - HIGH_OVERHEAD, HCNT_MIN));
    localparam logic [CNT_W-1:0] RST_FAST_L =
        CNT_W'(floor_at(ns_to_clk(CLK_KHZ, FAST_LOW_NS) - LOW_OVERHEAD, LCNT_MIN));
    localparam logic [CNT_W-1:0] H_MIN = CNT_W'(HCNT_MIN);
    localparam logic [CNT_W-1:0] L_MIN = CNT_W'(LCNT_MIN);

    logic [CNT_W-1:0] std_h, std_l, fast_h, fast_l, hold_q;
    logic             fast_q;

    function automatic logic [CNT_W-1:0] raise_to(logic [CNT_W-1:0] v, logic [CNT_W-1:0] lo);
        return (v < lo) ? lo : v;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            std_h  <= RST_STD_H;
            std_l  <= RST_STD_L;
            fast_h <= RST_FAST_H;
            fast_l <= RST_FAST_L;
            hold_q <= CNT_W'(1);
            fast_q <= 1'b0;
        end else if (cfg_we && !enable) begin
            case (cfg_addr)
                CFG_STD_HIGH:  std_h  <= raise_to(cfg_wdata, H_MIN);
                CFG_STD_LOW:   std_l  <= raise_to(cfg_wdata, L_MIN);
                CFG_FAST_HIGH: fast_h <= raise_to(cfg_wdata, H_MIN);
                CFG_FAST_LOW:  fast_l <= raise_to(cfg_wdata, L_MIN);
                CFG_HOLD:      hold_q <= cfg_wdata;
                CFG_SPEED:     fast_q <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    assign hcnt_o = fast_q ? fast_h : std_h;
    assign lcnt_o = fast_q ? fast_l : std_l;
    assign hold_o = hold_q;

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        $past(enable) |-> ($stable(std_h) && $stable(std_l) && $stable(fast_h)
                           && $stable(fast_l) && $stable(hold_q) && $stable(fast_q)));

    // R11
    cfg_min_chk: assert property (@(posedge clk) disable iff (rst)
        (std_h >= H_MIN) && (fast_h >= H_MIN) && (std_l >= L_MIN) && (fast_l >= L_MIN));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] lcnt,
    input  logic [CNT_W-1:0] hold,
    output logic             cmd_ready,
    output logic             scl_low,
    output logic             sda_launch,
    output logic             sda_sample,
    output logic             sda_edge,
    output logic             stretch_det
);
    localparam int PH_W = CNT_W + 2;

    phase_e          state, state_n;
    logic [PH_W-1:0] cnt, hi_last, hd_last, lo_last, launch_at;
    logic            is_high, high_done, take;

    assign hi_last   = PH_W'(hcnt) + PH_W'(HIGH_OVERHEAD - 1);
    assign hd_last   = PH_W'(hcnt) + PH_W'(START_HOLD_OVERHEAD - 1);
    assign lo_last   = PH_W'(lcnt) + PH_W'(LOW_OVERHEAD - 1);
    assign launch_at = (hold > lcnt) ? PH_W'(lcnt) : PH_W'(hold);

    assign is_high   = (state == ST_START_SU) || (state == ST_HIGH) || (state == ST_STOP_SU);
    assign high_done = is_high && scl_in && (cnt == hi_last);
    assign cmd_ready = enable && ((state == ST_IDLE) || (state == ST_PARK));
    assign take      = cmd_ready && cmd_valid;

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:     if (take && cmd_op == OP_START) state_n = ST_START_SU;
            ST_PARK: if (take) begin
                case (cmd_op)
                    OP_START: state_n = ST_START_SU;
                    OP_BIT:   state_n = ST_HIGH;
                    OP_STOP:  state_n = ST_STOP_SU;
                    default:  state_n = ST_PARK;
                endcase
            end
            ST_START_SU: if (high_done) state_n = ST_START_HD;
            ST_START_HD: if (cnt == hd_last) state_n = ST_LOW;
            ST_HIGH:     if (high_done) state_n = ST_LOW;
            ST_LOW:      if (cnt == lo_last) state_n = ST_PARK;
            ST_STOP_SU:  if (high_done) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
        if (!enable) state_n = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            if (state_n != state)
                cnt <= '0;
            else if (is_high ? scl_in : ((state == ST_LOW) || (state == ST_START_HD)))
                cnt <= cnt + PH_W'(1);
        end
    end

    assign scl_low     = (state == ST_LOW) || (state == ST_PARK);
    assign sda_launch  = (state == ST_LOW) && (cnt == launch_at);
    assign sda_sample  = (state == ST_HIGH) && scl_in && (cnt == '0);
    assign sda_edge    = ((state == ST_START_SU) || (state == ST_STOP_SU)) && high_done;
    assign stretch_det = is_high && !scl_in;

    // R3
    low_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOW) |-> (cnt <= lo_last));

    // R4
    sample_chk: assert property (@(posedge clk) disable iff (rst)
        sda_sample |-> (scl_in && !scl_low));

    // R5
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        (is_high && !scl_in && enable) |=> (cnt == $past(cnt)));

    // R6
    edge_chk: assert property (@(posedge clk) disable iff (rst)
        sda_edge |-> (scl_in && !scl_low));

    // R8
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        sda_launch |-> scl_low);

    // R12
    disable_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state == ST_IDLE && !scl_low));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CLK_KHZ = 100000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  cfg_we,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]      cfg_wdata,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    output logic                  cmd_ready,
    input  logic                  scl_in,
    output logic                  scl_low,
    output logic                  sda_launch,
    output logic                  sda_sample,
    output logic                  sda_edge,
    output logic                  stretch_det
);
    logic [CNT_W-1:0] hcnt, lcnt, hold;

    scl_cfg_regs #(.CNT_W(CNT_W), .CLK_KHZ(CLK_KHZ)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .hcnt_o    (hcnt),
        .lcnt_o    (lcnt),
        .hold_o    (hold)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .scl_in      (scl_in),
        .hcnt        (hcnt),
        .lcnt        (lcnt),
        .hold        (hold),
        .cmd_ready   (cmd_ready),
        .scl_low     (scl_low),
        .sda_launch  (sda_launch),
        .sda_sample  (sda_sample),
        .sda_edge    (sda_edge),
        .stretch_det (stretch_det)
    );

endmodule

// File: tb/scl_clock_gen_bench.sv
`timescale 1ns/1ps
module scl_clock_gen_bench;
    localparam int CNT_W   = 16;
    localparam int CLK_KHZ = 100000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enable = 1'b1;
    logic             cfg_we = 1'b0;
    logic [2:0]       cfg_addr = '0;
    logic [CNT_W-1:0] cfg_wdata = '0;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_op = 2'b00;
    logic             cmd_ready, scl_in, scl_low;
    logic             sda_launch, sda_sample, sda_edge, stretch_det;
    logic             stretch = 1'b0;

    assign scl_in = !(scl_low || stretch);

    always #2 clk = ~clk;

    scl_clock_gen #(.CNT_W(CNT_W), .CLK_KHZ(CLK_KHZ)) u_scl_clock_gen (
        .clk(clk), .rst(rst), .enable(enable), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ready(cmd_ready),
        .scl_in(scl_in), .scl_low(scl_low), .sda_launch(sda_launch), .sda_sample(sda_sample),
        .sda_edge(sda_edge), .stretch_det(stretch_det)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    int m_rel, m_low, m_launch_idx, m_launch_n, m_sample_idx, m_sample_n;
    int m_edge_idx, m_edge_n, m_str;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CNT_W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
    endtask

    // issue a command, then record the waveform until the block is ready again
    task automatic do_cmd(input logic [1:0] op, input int s);
        int guard;
        guard = 0;
        while (!cmd_ready && guard < 10000) begin
            @(negedge clk); #1; guard++;
        end
        m_rel = 0; m_low = 0; m_launch_idx = -1; m_launch_n = 0;
        m_sample_idx = -1; m_sample_n = 0; m_edge_idx = -1; m_edge_n = 0; m_str = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        for (int i = 0; i < 20000; i++) begin
            stretch = !scl_low && (m_rel < s);
            #1;
            if (cmd_ready) break;
            if (!scl_low) begin
                if (sda_sample) begin m_sample_idx = m_rel; m_sample_n++; end
                if (sda_edge) begin m_edge_idx = m_rel; m_edge_n++; end
                if (stretch_det) m_str++;
                m_rel++;
            end else begin
                if (sda_launch) begin m_launch_idx = m_low; m_launch_n++; end
                m_low++;
            end
            @(negedge clk);
        end
        stretch = 1'b0;
    endtask

    typedef struct packed {
        int std_h; int std_l; int fast_h; int fast_l; int fast;
        int hold; int str; int e_hi; int e_lo; int e_launch;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{10, 12, 6, 8, 0,  2, 0, 18, 13,  2},
        '{10, 12, 6, 8, 1,  2, 0, 14,  9,  2},
        '{20,  9, 7, 11, 0, 0, 3, 31, 10,  0},
        '{20,  9, 7, 11, 1, 5, 4, 19, 12,  5},
        '{ 3,  2, 6, 8, 0,  1, 0, 14,  9,  1},  // R11 clamp vector
        '{12, 10, 6, 8, 0, 30, 0, 20, 11, 10}   // R8 hold beyond low count
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int h0, std_h_def, std_l_def, bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 scl_low", int'(scl_low), 0);
        chk("R1 cmd_ready", int'(cmd_ready), 1);
        chk("R1 strobes", int'({sda_launch, sda_sample, sda_edge, stretch_det}), 0);

        // R2 default counts
        std_h_def = (CLK_KHZ * 4000 + 500000) / 1000000 - 8;
        std_l_def = (CLK_KHZ * 4700 + 500000) / 1000000 - 1;
        do_cmd(2'b01, 0);
        chk("R2 start released", m_rel, 2 * std_h_def + 11);
        chk("R2 low length", m_low, std_l_def + 1);
        chk("R2 launch index", m_launch_idx, 1);

        // R10 writes while enabled are ignored
        cfg_write(3'd1, 8);
        cfg_write(3'd5, 1);
        do_cmd(2'b10, 0);
        chk("R10 high after locked write", m_rel, std_h_def + 8);
        chk("R10 low after locked write", m_low, std_l_def + 1);
        do_cmd(2'b11, 0);
        chk("R10 stop length", m_rel, std_h_def + 8);

        foreach (VECS[v]) begin
            @(negedge clk); enable = 1'b0;
            cfg_write(3'd0, VECS[v].std_h);
            cfg_write(3'd1, VECS[v].std_l);
            cfg_write(3'd2, VECS[v].fast_h);
            cfg_write(3'd3, VECS[v].fast_l);
            cfg_write(3'd4, VECS[v].hold);
            cfg_write(3'd5, VECS[v].fast);
            @(negedge clk); enable = 1'b1; #1;
            h0 = VECS[v].e_hi - VECS[v].str;

            do_cmd(2'b01, 0);
            chk("R6/R9 start released", m_rel, 2 * h0 - 5);
            chk("R6 start edge index", m_edge_idx, h0 - 1);
            chk("R3/R9/R11 low length", m_low, VECS[v].e_lo);
            chk("R8 launch index", m_launch_idx, VECS[v].e_launch);
            chk("R8 launch count", m_launch_n, 1);

            do_cmd(2'b10, VECS[v].str);
            chk("R4/R5 bit released", m_rel, VECS[v].e_hi);
            chk("R4 sample index", m_sample_idx, VECS[v].str);
            chk("R4 sample count", m_sample_n, 1);
            chk("R5 stretch cycles", m_str, VECS[v].str);
            chk("R3 bit low length", m_low, VECS[v].e_lo);
            chk("R8 bit launch index", m_launch_idx, VECS[v].e_launch);

            do_cmd(2'b11, 0);
            chk("R7 stop released", m_rel, h0);
            chk("R7 stop edge index", m_edge_idx, h0 - 1);
            chk("R7 stop low cycles", m_low, 0);
            chk("R7 idle ready", int'(cmd_ready && !scl_low), 1);
        end

        // R12 bit and stop ignored while idle
        bad = 0;
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b10;
        @(negedge clk); cmd_op = 2'b11;
        @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00;
        for (int i = 0; i < 6; i++) begin
            #1;
            if (scl_low || !cmd_ready || sda_edge) bad++;
            @(negedge clk);
        end
        chk("R12 idle ignores bit/stop", bad, 0);

        // R12 disable during a low phase
        @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'b01;
        @(negedge clk); cmd_valid = 1'b0; cmd_op = 2'b00;
        for (int i = 0; i < 200 && !scl_low; i++) @(negedge clk);
        enable = 1'b0;
        @(negedge clk); #1;
        chk("R12 released after disable", int'(scl_low), 0);
        chk("R12 not ready while disabled", int'(cmd_ready), 0);
        @(negedge clk); enable = 1'b1; #1;
        chk("R12 idle after re-enable", int'(cmd_ready && !scl_low), 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule